// File: doc/BRIEF.md
# Masked Interrupt Event Aggregator

The block gathers single-cycle event pulses from a network controller's transmit and receive engines into a 32-bit event register. A 32-bit mask register sits beside it, and the block drives thirteen interrupt lines. Each line follows the logical AND of one event bit and the matching mask bit.

Software reads either register over a small register bus. It sets the mask by writing the whole word. It acknowledges events by writing ones to the event register, and each one clears its bit. A synchronous clear command empties both registers. The lines are registered: they take their new value at the same clock edge that stores the causing pulse or write in the registers.

The thirteen event sources occupy the top thirteen bits of the event register. The lines do not follow those bits in register order. They follow a fixed permutation.

Top module: `irq_event_agg`

## Requirements
- R1: Pulse input `evt_pulse_i[k]` sets event register bit 19+k. The sources for k = 0..12 are: underrun, retry limit, late collision, bus error, management done, receive buffer, receive frame, transmit buffer, transmit frame, graceful stop complete, babbling transmit, babbling receive, heartbeat.
- R2: Lines 0..12 follow event register bits 27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30, in that order. In source names these are: transmit frame, transmit buffer, underrun, retry limit, receive frame, receive buffer, management done, late collision, heartbeat, graceful stop, bus error, babbling transmit, babbling receive.
- R3: A line is 1 exactly when its event bit and its mask bit are both 1. The line takes the new value at the clock edge that samples the causing pulse or write. Before that edge it keeps its old value.
- R4: A write with `bus_sel_i` = 0 targets the event register. Each event bit whose written bit is 1 is cleared. Every other event bit keeps its value.
- R5: A write with `bus_sel_i` = 1 replaces all 32 bits of the mask register.
- R6: `bus_rdata_o` shows the event register when `bus_sel_i` = 0 and the mask register when `bus_sel_i` = 1. It reflects the contents as they stand after the last clock edge.
- R7: `soft_clr_i` high at a clock edge clears both registers and drives every line low at that edge. In that cycle it overrides any pulse and any write.
- R8: If a pulse and a write-one-to-clear hit the same event bit in one cycle, the bit ends up set.
- R9: Event register bits 18..0 always read 0. No pulse or write can set them.
- R10: After `rst_n` is asserted, both registers are 0 and all lines are low.
- R11: An event bit does not change in a cycle with no pulse, no event-register write and no clear command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_clr_i | input | 1 | Synchronous clear command for both registers |
| evt_pulse_i | input | 13 | Single-cycle event pulses, bit k sets register bit 19+k |
| bus_we_i | input | 1 | Register write strobe |
| bus_sel_i | input | 1 | Register select: 0 event, 1 mask |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the selected register |
| irq_o | output | 13 | Interrupt lines |

## Verification
The bound checker checks the following on every cycle:
- The lines equal the permuted AND of the two registers.
- The low event bits stay zero.
- Write-one-to-clear never clears an unwritten bit and never leaves a written bit set unless a pulse hit it.
- The mask takes written words exactly.
- The clear command empties everything.
- Idle cycles leave the event register alone.

Only the bench scenarios can show the following:
- Which named source lands on which line.
- That a line is still at its old value just before the edge.
- That reads pick the register named by the select.

// File: rtl/evt_agg_pkg.sv
package evt_agg_pkg;

    localparam int unsigned REG_W     = 32;
    localparam int unsigned NUM_SRC   = 13;
    localparam int unsigned SRC_LSB   = REG_W - NUM_SRC;

    typedef enum logic {
        SEL_EVENT = 1'b0,
        SEL_MASK  = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] evt;
        logic [REG_W-1:0] msk;
    } agg_regs_t;

    // register bit that drives each interrupt line
    function automatic int unsigned line_src_bit(input int unsigned line);
        case (line)
            0:       line_src_bit = 27;
            1:       line_src_bit = 26;
            2:       line_src_bit = 19;
            3:       line_src_bit = 20;
            4:       line_src_bit = 25;
            5:       line_src_bit = 24;
            6:       line_src_bit = 23;
            7:       line_src_bit = 21;
            8:       line_src_bit = 31;
            9:       line_src_bit = 28;
            10:      line_src_bit = 22;
            11:      line_src_bit = 29;
            12:      line_src_bit = 30;
            default: line_src_bit = SRC_LSB;
        endcase
    endfunction

endpackage

// File: rtl/evt_set_expand.sv
module evt_set_expand #(
    parameter int unsigned DATA_W  = evt_agg_pkg::REG_W,
    parameter int unsigned NUM_EVT = evt_agg_pkg::NUM_SRC
) (
    input  logic [NUM_EVT-1:0] pulse_i,
    output logic [DATA_W-1:0]  set_vec_o
);
    localparam int unsigned LOW_W = DATA_W - NUM_EVT;

    // sources occupy the top of the word; low part can never be set
    assign set_vec_o = {pulse_i, {LOW_W{1'b0}}};
endmodule

// File: rtl/evt_line_map.sv
module evt_line_map #(
    parameter int unsigned DATA_W    = evt_agg_pkg::REG_W,
    parameter int unsigned NUM_LINES = evt_agg_pkg::NUM_SRC
) (
    input  logic [DATA_W-1:0]    active_i,
    output logic [NUM_LINES-1:0] lines_o
);
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        localparam int unsigned SRC = evt_agg_pkg::line_src_bit(g);
        assign lines_o[g] = active_i[SRC];
    end
endmodule

// File: rtl/evt_rd_mux.sv
module evt_rd_mux #(
    parameter int unsigned DATA_W = evt_agg_pkg::REG_W
) (
    input  logic              sel_i,
    input  logic [DATA_W-1:0] evt_i,
    input  logic [DATA_W-1:0] msk_i,
    output logic [DATA_W-1:0] rdata_o
);
    assign rdata_o = (sel_i == evt_agg_pkg::SEL_MASK) ? msk_i : evt_i;
endmodule

// File: rtl/irq_event_agg.sv
module irq_event_agg
    import evt_agg_pkg::*;
#(
    parameter int unsigned DATA_W    = REG_W,
    parameter int unsigned NUM_LINES = NUM_SRC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_clr_i,
    input  logic [NUM_LINES-1:0] evt_pulse_i,
    input  logic                 bus_we_i,
    input  logic                 bus_sel_i,
    input  logic [DATA_W-1:0]    bus_wdata_i,
    output logic [DATA_W-1:0]    bus_rdata_o,
    output logic [NUM_LINES-1:0] irq_o
);
    agg_regs_t              regs_d, regs_q;
    logic [NUM_LINES-1:0]   irq_d, irq_q;
    logic [DATA_W-1:0]      set_vec;
    logic [DATA_W-1:0]      active_d;
    logic [DATA_W-1:0]      evt_cur;
    logic [DATA_W-1:0]      msk_cur;

    evt_set_expand #(.DATA_W(DATA_W), .NUM_EVT(NUM_LINES)) u_expand (
        .pulse_i   (evt_pulse_i),
        .set_vec_o (set_vec)
    );

    always_comb begin
        regs_d = regs_q;
        if (bus_we_i && bus_sel_i == SEL_EVENT) begin
            regs_d.evt = regs_q.evt & ~bus_wdata_i;
        end
        if (bus_we_i && bus_sel_i == SEL_MASK) begin
            regs_d.msk = bus_wdata_i;
        end
        // a new pulse wins over a same-cycle acknowledge
        regs_d.evt = regs_d.evt | set_vec;
        if (soft_clr_i) begin
            regs_d.evt = '0;
            regs_d.msk = '0;
        end
    end

    assign active_d = regs_d.evt & regs_d.msk;

    evt_line_map #(.DATA_W(DATA_W), .NUM_LINES(NUM_LINES)) u_map (
        .active_i (active_d),
        .lines_o  (irq_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
            irq_q  <= '0;
        end else begin
            regs_q <= regs_d;
            irq_q  <= irq_d;
        end
    end

    assign evt_cur = regs_q.evt;
    assign msk_cur = regs_q.msk;

    evt_rd_mux #(.DATA_W(DATA_W)) u_rd (
        .sel_i   (bus_sel_i),
        .evt_i   (evt_cur),
        .msk_i   (msk_cur),
        .rdata_o (bus_rdata_o)
    );

    assign irq_o = irq_q;
endmodule

// File: rtl/evt_agg_chk.sv
module evt_agg_chk
    import evt_agg_pkg::*;
#(
    parameter int unsigned DATA_W    = REG_W,
    parameter int unsigned NUM_LINES = NUM_SRC
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 soft_clr,
    input logic [NUM_LINES-1:0] pulse,
    input logic                 we,
    input logic                 sel,
    input logic [DATA_W-1:0]    wdata,
    input logic [DATA_W-1:0]    evt,
    input logic [DATA_W-1:0]    msk,
    input logic [NUM_LINES-1:0] irq
);
    localparam int unsigned LOW_W = DATA_W - NUM_LINES;

    logic [DATA_W-1:0]    pulse_word;
    logic [DATA_W-1:0]    both;
    logic [NUM_LINES-1:0] exp_lines;

    assign pulse_word = {pulse, {LOW_W{1'b0}}};
    assign both       = evt & msk;

    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) begin
            exp_lines[i] = both[line_src_bit(i)];
        end
    end

    // R2 and R3: lines track the permuted masked events
    a_r3_lines_match: assert property (@(posedge clk) disable iff (!rst_n)
        irq == exp_lines);

    // R9: unused low event bits stay zero
    a_r9_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        evt[LOW_W-1:0] == '0);

    // R4: acknowledged bits clear unless a pulse hit them
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_EVENT && !soft_clr)
        |=> ((evt & $past(wdata) & ~$past(pulse_word)) == '0));

    // R4: unacknowledged bits survive a write
    a_r4_ack_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_EVENT && !soft_clr)
        |=> (($past(evt) & ~$past(wdata) & ~evt) == '0));

    // R5: mask takes the written word
    a_r5_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_MASK && !soft_clr) |=> (msk == $past(wdata)));

    // R7: clear command empties both registers and all lines
    a_r7_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (evt == '0 && msk == '0 && irq == '0));

    // R8: a pulsed bit is set afterwards
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_clr && pulse != '0) |=> ((evt & $past(pulse_word)) == $past(pulse_word)));

    // R11: event register holds without a cause
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_clr && pulse == '0 && !(we && sel == SEL_EVENT)) |=> $stable(evt));
endmodule

bind irq_event_agg evt_agg_chk #(.DATA_W(DATA_W), .NUM_LINES(NUM_LINES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (soft_clr_i),
    .pulse    (evt_pulse_i),
    .we       (bus_we_i),
    .sel      (bus_sel_i),
    .wdata    (bus_wdata_i),
    .evt      (evt_cur),
    .msk      (msk_cur),
    .irq      (irq_o)
);

// File: tb/sim_irq_event_agg.sv
`timescale 1ns/1ps
module sim_irq_event_agg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_clr_i = 1'b0;
    logic [12:0] evt_pulse_i = '0;
    logic        bus_we_i = 1'b0;
    logic        bus_sel_i = 1'b0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic [12:0] irq_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_evt = '0;
    logic [31:0] m_msk = '0;

    always #2.5 clk = ~clk;

    irq_event_agg u0 (
        .clk(clk), .rst_n(rst_n), .soft_clr_i(soft_clr_i),
        .evt_pulse_i(evt_pulse_i), .bus_we_i(bus_we_i), .bus_sel_i(bus_sel_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
    );

    // R2 table, written from the requirement
    function automatic int src_of_line(input int l);
        int t[13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};
        return t[l];
    endfunction

    function automatic logic [12:0] exp_lines(input logic [31:0] e, input logic [31:0] m);
        logic [12:0] r;
        for (int l = 0; l < 13; l++) r[l] = e[src_of_line(l)] & m[src_of_line(l)];
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one bus cycle: drive at negedge, update model at posedge, settle
    task automatic step(input logic [12:0] p, input logic we, input logic sel,
                        input logic [31:0] wd, input logic clr);
        @(negedge clk);
        evt_pulse_i = p; bus_we_i = we; bus_sel_i = sel; bus_wdata_i = wd; soft_clr_i = clr;
        @(posedge clk);
        if (we && !sel) m_evt = m_evt & ~wd;
        if (we && sel)  m_msk = wd;
        m_evt = m_evt | {p, 19'b0};
        if (clr) begin m_evt = '0; m_msk = '0; end
        #1;
        evt_pulse_i = '0; bus_we_i = 1'b0; soft_clr_i = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic sel);
        bus_sel_i = sel;
        #0.5;
        chk(req, bus_rdata_o, sel ? m_msk : m_evt);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        chk("R10 lines", {19'b0, irq_o}, 32'h0);
        read_chk("R10 event", 1'b0);
        read_chk("R10 mask", 1'b1);
        rst_n = 1'b1;

        // R1 and R2: each source alone, full mask
        for (int k = 0; k < 13; k++) begin
            step('0, 1'b0, 1'b0, '0, 1'b1);
            step('0, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0);
            step(13'd1 << k, 1'b0, 1'b0, '0, 1'b0);
            read_chk("R1 source position", 1'b0);
            chk("R2 line mapping", {19'b0, irq_o}, {19'b0, exp_lines(m_evt, m_msk)});
        end

        // R3 timing: line stays old before the edge, new after it
        step('0, 1'b0, 1'b0, '0, 1'b1);
        step('0, 1'b1, 1'b1, 32'h0800_0000, 1'b0);
        @(negedge clk);
        evt_pulse_i = 13'd1 << 8;
        #1;
        chk("R3 before edge", {19'b0, irq_o}, 32'h0);
        @(posedge clk);
        m_evt = m_evt | 32'h0800_0000;
        #1;
        evt_pulse_i = '0;
        chk("R3 after edge", {19'b0, irq_o}, 32'h1);
        // R3 masked bit does not raise a line
        step(13'd1 << 7, 1'b0, 1'b0, '0, 1'b0);
        chk("R3 masked source", {19'b0, irq_o}, 32'h1);

        // R4 partial acknowledge
        step(13'h1FFF, 1'b0, 1'b0, '0, 1'b0);
        step('0, 1'b1, 1'b0, 32'hA000_0000, 1'b0);
        read_chk("R4 partial clear", 1'b0);

        // R8 pulse and acknowledge on the same bit
        step(13'd1 << 5, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0);
        read_chk("R8 set wins", 1'b0);

        // R9 ones written to low bits leave them zero
        step(13'h1FFF, 1'b1, 1'b0, 32'h0007_FFFF, 1'b0);
        read_chk("R9 low bits", 1'b0);

        // R5 mask replace
        step('0, 1'b1, 1'b1, 32'h1234_5678, 1'b0);
        read_chk("R5 mask replace", 1'b1);

        // R7 clear overrides pulse and writes in the same cycle
        step(13'h1FFF, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b1);
        read_chk("R7 event cleared", 1'b0);
        read_chk("R7 mask cleared", 1'b1);
        chk("R7 lines low", {19'b0, irq_o}, 32'h0);

        // R11 idle cycles leave the event register unchanged
        step(13'h0421, 1'b0, 1'b0, '0, 1'b0);
        step('0, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0);
        step('0, 1'b0, 1'b0, '0, 1'b0);
        read_chk("R11 hold", 1'b0);

        // random mix, R3 R4 R5 R6 R8 R9 against the model
        for (int c = 0; c < 3000; c++) begin
            logic [12:0] p;
            logic        we, sel, clr;
            logic [31:0] wd;
            p   = ($urandom % 4 == 0) ? 13'($urandom) : 13'h0;
            we  = $urandom % 2 == 1;
            sel = $urandom % 2 == 1;
            wd  = ($urandom % 8 == 0) ? 32'hFFFF_FFFF : $urandom;
            clr = $urandom % 64 == 0;
            step(p, we, sel, wd, clr);
            chk("R3 random lines", {19'b0, irq_o}, {19'b0, exp_lines(m_evt, m_msk)});
            read_chk("R6 random read", $urandom % 2 == 1);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule